// File: doc/BRIEF.md
# Reset Supervisor with Pushbutton Monitor

This block controls the active-low reset line of a microprocessor. An external comparator supplies a synchronous flag, `supply_ok`, that is high while the supply rail is above its trip point. The reset line is a shared open-drain wire: this block pulls it low through `drive_low`, a pushbutton may also short it to ground, and a pull-up raises it otherwise. The block reads the resulting wire level back on `pin_level`.

The line is held low for as long as the supply is below threshold. Once the supply recovers, the line stays low for a programmable number of clock cycles. A brownout during that interval starts the interval again.

While no reset is running, the block watches its own line for a press. A low-going edge makes the block pull the line low for a debounce interval. It then lets go and looks at the wire. If the wire has already returned high, the block goes back to idle. If the wire is still low, the block waits for the button to be released and then issues a full-length reset.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, the block enters its supply-reset state. From the clock edge after `rst` is first sampled high, `drive_low` and `reset_active` are both 1.
- R2: Whenever `supply_ok` is sampled 0, `drive_low` is 1 after that clock edge. When `drive_low` falls, `supply_ok` was 1 at that edge.
- R3: After `supply_ok` is first sampled 1 in the supply-reset state, `drive_low` stays 1 for exactly RESET_CYCLES clock cycles and then goes to 0.
- R4: If `supply_ok` drops during a reset stretch, the stretch restarts. `drive_low` is released only after RESET_CYCLES cycles of continuous `supply_ok` following the recovery.
- R5: In idle, a falling edge of the synchronized `pin_level` (1 = wire high, 0 = wire low) makes `drive_low` go to 1 three clock cycles after the wire falls. It stays 1 for DEBOUNCE_CYCLES cycles.
- R6: After the debounce interval, `drive_low` is 0 for SYNC_STAGES+1 settle cycles. If the synchronized wire is high at the end of the settle cycles, the block returns to idle and issues no reset.
- R7: If the wire is still low at the end of the settle cycles, `drive_low` stays 0 until a rising edge of the wire. The block then pulls low for RESET_CYCLES cycles.
- R8: Wire edges that occur while a reset stretch is running have no effect on its length.
- R9: A `supply_ok` drop during debounce or during the wait for release abandons the button sequence. The block enters the supply-reset state, and its recovery follows R3.
- R10: `reset_active` is 1 in exactly the cycles where `drive_low` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Synchronous flag, 1 while the supply is above threshold |
| pin_level | input | 1 | Sensed level of the shared reset wire (1 = high), asynchronous |
| drive_low | output | 1 | Open-drain enable, 1 pulls the reset wire low |
| reset_active | output | 1 | 1 while the block is holding the wire low |

## Verification
The assertions assume that `supply_ok` is already synchronous to `clk`. They also assume that `pin_level` is low whenever `drive_low` is 1, which is the wired-AND behaviour of an open-drain line. The bench models the wire as the AND of the pull-up, the block's enable and a button, so `pin_level` cannot be high while the block drives low. Button presses and releases are held for several cycles, longer than the synchronizer latency, which keeps each edge visible to the two-flop input stage.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic [2:0] {
    ST_SUPPLY   = 3'd0,
    ST_STRETCH  = 3'd1,
    ST_IDLE     = 3'd2,
    ST_DEBOUNCE = 3'd3,
    ST_SETTLE   = 3'd4,
    ST_WAIT_REL = 3'd5
  } rsv_state_e;

  // States in which the supervisor pulls the shared line low.
  function automatic logic rsv_drives(input rsv_state_e s);
    return (s == ST_SUPPLY) || (s == ST_STRETCH) || (s == ST_DEBOUNCE);
  endfunction

endpackage

// File: rtl/rsv_pin_sync.sv
module rsv_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  output logic level,
  output logic fell,
  output logic rose
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // Stage 0 samples the asynchronous wire; later stages form the chain.
  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b1;
    else     chain_q[0] <= pin_async;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain_q[g] <= 1'b1;
      else     chain_q[g] <= chain_q[g-1];
    end
  end

  // One extra flop holds the previous synchronized level for edge detection.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level = chain_q[STAGES-1];
  assign fell  = prev_q & ~level;
  assign rose  = ~prev_q & level;

endmodule

// File: rtl/rsv_timer.sv
module rsv_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  // Counts down from the loaded value and rests at zero.
  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/rsv_fsm.sv
module rsv_fsm
  import rsv_pkg::*;
#(
  parameter int RESET_CYCLES    = 16,
  parameter int DEBOUNCE_CYCLES = 16,
  parameter int SETTLE_CYCLES   = 3,
  parameter int W               = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         supply_ok,
  input  logic         pin_level,
  input  logic         pin_fell,
  input  logic         pin_rose,
  input  logic         expired,
  output logic         load,
  output logic [W-1:0] load_val,
  output logic         drive_q,
  output logic         active_q
);

  localparam logic [W-1:0] LD_RESET  = W'(RESET_CYCLES - 1);
  localparam logic [W-1:0] LD_DEB    = W'(DEBOUNCE_CYCLES - 1);
  localparam logic [W-1:0] LD_SETTLE = W'(SETTLE_CYCLES - 1);

  rsv_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    if (!supply_ok) begin
      // Brownout always wins, from every state.
      state_d = ST_SUPPLY;
    end else begin
      unique case (state_q)
        ST_SUPPLY: begin
          state_d  = ST_STRETCH;
          load     = 1'b1;
          load_val = LD_RESET;
        end
        ST_STRETCH: begin
          if (expired) state_d = ST_IDLE;
        end
        ST_IDLE: begin
          if (pin_fell) begin
            state_d  = ST_DEBOUNCE;
            load     = 1'b1;
            load_val = LD_DEB;
          end
        end
        ST_DEBOUNCE: begin
          if (expired) begin
            state_d  = ST_SETTLE;
            load     = 1'b1;
            load_val = LD_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (expired) state_d = pin_level ? ST_IDLE : ST_WAIT_REL;
        end
        ST_WAIT_REL: begin
          if (pin_rose) begin
            state_d  = ST_STRETCH;
            load     = 1'b1;
            load_val = LD_RESET;
          end
        end
        default: state_d = ST_SUPPLY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_SUPPLY;
      drive_q  <= 1'b1;
      active_q <= 1'b1;
    end else begin
      state_q  <= state_d;
      drive_q  <= rsv_drives(state_d);
      active_q <= rsv_drives(state_d);
    end
  end

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int RESET_CYCLES    = 16,
  parameter int DEBOUNCE_CYCLES = RESET_CYCLES,
  parameter int SYNC_STAGES     = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic pin_level,
  output logic drive_low,
  output logic reset_active
);

  localparam int SETTLE_CYCLES = SYNC_STAGES + 1;
  localparam int MAX_CYCLES    = (RESET_CYCLES > DEBOUNCE_CYCLES) ? RESET_CYCLES : DEBOUNCE_CYCLES;
  localparam int TW            = $clog2(MAX_CYCLES + 1) + 1;

  logic          s_level, s_fell, s_rose;
  logic          t_load, t_expired;
  logic [TW-1:0] t_val;

  rsv_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pin_async (pin_level),
    .level     (s_level),
    .fell      (s_fell),
    .rose      (s_rose)
  );

  rsv_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  rsv_fsm #(
    .RESET_CYCLES    (RESET_CYCLES),
    .DEBOUNCE_CYCLES (DEBOUNCE_CYCLES),
    .SETTLE_CYCLES   (SETTLE_CYCLES),
    .W               (TW)
  ) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .pin_level (s_level),
    .pin_fell  (s_fell),
    .pin_rose  (s_rose),
    .expired   (t_expired),
    .load      (t_load),
    .load_val  (t_val),
    .drive_q   (drive_low),
    .active_q  (reset_active)
  );

endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
  parameter int RESET_CYCLES = 16
) (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic drive_low,
  input logic reset_active
);

  // Counts consecutive cycles of good supply since the last drop or reset.
  int unsigned ok_run;
  always_ff @(posedge clk) begin
    if (rst || !supply_ok)             ok_run <= 0;
    else if (ok_run < RESET_CYCLES + 4) ok_run <= ok_run + 1;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (drive_low && reset_active));

  p_brownout_drive_r2: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> drive_low);

  p_release_supply_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_low) |-> $past(supply_ok));

  p_min_stretch_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_low) |-> (ok_run >= RESET_CYCLES));

  p_active_follows_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_low) |-> reset_active);

endmodule

bind rst_supervisor rsv_checker #(.RESET_CYCLES(RESET_CYCLES)) u_rsv_checker (
  .clk          (clk),
  .rst          (rst),
  .supply_ok    (supply_ok),
  .drive_low    (drive_low),
  .reset_active (reset_active)
);

// File: tb/test_rst_supervisor.sv
module test_rst_supervisor;

  localparam int RC = 16;
  localparam int DB = 8;
  localparam int NV = 23;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b0;
  logic btn = 1'b0;
  logic pin_level;
  logic drive_low, reset_active;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #10 clk = ~clk;

  // Open-drain wire: low if the block or the button pulls it down.
  assign pin_level = ~(drive_low | btn);

  rst_supervisor #(.RESET_CYCLES(RC), .DEBOUNCE_CYCLES(DB), .SYNC_STAGES(2)) i_rst_supervisor (
    .clk          (clk),
    .rst          (rst),
    .supply_ok    (supply_ok),
    .pin_level    (pin_level),
    .drive_low    (drive_low),
    .reset_active (reset_active)
  );

  // Vector: {supply_ok, button, cycles to wait, expected drive_low}
  localparam logic [10:0] VEC [0:NV-1] = '{
    {1'b0, 1'b0, 8'd5,  1'b1},  // R2 supply low
    {1'b1, 1'b0, 8'd10, 1'b1},  // R3 stretching
    {1'b1, 1'b0, 8'd10, 1'b0},  // R3 released
    {1'b0, 1'b0, 8'd3,  1'b1},  // R2 brownout
    {1'b1, 1'b0, 8'd12, 1'b1},  // R4 restarted stretch
    {1'b1, 1'b0, 8'd10, 1'b0},  // R4 released
    {1'b1, 1'b1, 8'd4,  1'b1},  // R5 debounce drive
    {1'b1, 1'b0, 8'd20, 1'b0},  // R6 quick release, no reset
    {1'b1, 1'b1, 8'd4,  1'b1},  // R5 debounce drive
    {1'b1, 1'b1, 8'd20, 1'b0},  // R7 waiting for release
    {1'b1, 1'b0, 8'd6,  1'b1},  // R7 release -> reset
    {1'b1, 1'b0, 8'd8,  1'b1},  // R7 reset held
    {1'b1, 1'b0, 8'd12, 1'b0},  // R7 reset over
    {1'b1, 1'b1, 8'd4,  1'b1},  // R9 debounce
    {1'b0, 1'b0, 8'd4,  1'b1},  // R9 brownout in debounce
    {1'b1, 1'b0, 8'd10, 1'b1},  // R9 full stretch
    {1'b1, 1'b0, 8'd10, 1'b0},  // R9 released
    {1'b1, 1'b0, 8'd10, 1'b0},  // R6 stays idle
    {1'b1, 1'b1, 8'd4,  1'b1},  // R9 debounce
    {1'b1, 1'b1, 8'd20, 1'b0},  // R7 waiting
    {1'b0, 1'b1, 8'd3,  1'b1},  // R9 brownout in wait
    {1'b1, 1'b0, 8'd10, 1'b1},  // R8 release during stretch ignored
    {1'b1, 1'b0, 8'd10, 1'b0}   // R8 stretch length unchanged
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b (time %0t)", req, act, exp, $time);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    wait_cycles(3);
    check("R1 reset drive", drive_low, 1'b1);
    check("R1 reset active", reset_active, 1'b1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      supply_ok = VEC[i][10];
      btn       = VEC[i][9];
      wait_cycles(int'(VEC[i][8:1]));
      check($sformatf("vector %0d drive", i), drive_low, VEC[i][0]);
      check($sformatf("R10 vector %0d active", i), reset_active, VEC[i][0]);
    end

    // R1: reset from idle forces the line low on the next edge.
    rst = 1'b1;
    wait_cycles(1);
    check("R1 reset from idle", drive_low, 1'b1);
    check("R1 active from idle", reset_active, 1'b1);

    // R3: exact stretch length with supply already good.
    supply_ok = 1'b1;
    wait_cycles(1);
    rst = 1'b0;
    wait_cycles(1);
    n = 0;
    while (drive_low === 1'b1 && n < 4 * RC) begin
      n++;
      @(negedge clk);
    end
    checks++;
    if (n != RC) begin
      fails++;
      $display("FAIL R3 stretch length: actual %0d expected %0d", n, RC);
    end

    // R5: exact debounce length.
    wait_cycles(4);
    btn = 1'b1;
    n = 0;
    while (drive_low !== 1'b1 && n < 10) begin
      n++;
      @(negedge clk);
    end
    checks++;
    if (n != 3) begin
      fails++;
      $display("FAIL R5 detect latency: actual %0d expected 3", n);
    end
    btn = 1'b0;
    n = 0;
    while (drive_low === 1'b1 && n < 4 * DB) begin
      n++;
      @(negedge clk);
    end
    checks++;
    if (n != DB) begin
      fails++;
      $display("FAIL R5 debounce length: actual %0d expected %0d", n, DB);
    end
    wait_cycles(RC + 4);
    check("R6 no reset after quick release", drive_low, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule